// File: doc/BRIEF.md
# Strided Byte-to-Lane Vector Loader

This block fills a 128-bit vector register with eight 16-bit fixed-point lanes built from single bytes of a byte-addressed data memory. On a request it forms an effective address from a base and a signed 7-bit offset scaled by 16. It clears the low three bits to get an 8-byte-aligned window and derives a 4-bit rotation from the address's low bits and a start-element index. It then gathers eight bytes at a stride of four with wraparound modulo 16 inside that window.

Each byte becomes a lane value by zero-extension and a left shift by seven. The eight lanes are packed big-endian, and a start-dependent byte range of the result replaces the matching bytes of the previous register value supplied with the request. The merged register is presented with a one-cycle done pulse. The memory sits outside the block and answers one byte per read, one cycle after the read is issued.

Top module: `strided_lane_loader`

## Requirements
- R1: While reset is held and after its release with no request, `done` and `mem_rd_en` are low.
- R2: The effective address is `base_addr + sign_extend(offset) * 16`, taken modulo 2^AW.
- R3: An accepted request issues exactly eight reads, one per cycle, in lane order 0 to 7, starting in the cycle after acceptance.
- R4: With window W = effective address with bits [2:0] cleared and rotation r = (effective address[2:0] - start_idx) mod 16, lane k (k = 0..3) reads address W + ((r + 4k) mod 16), modulo 2^AW.
- R5: Lane k+4 (k = 0..3) reads address W + ((r + 4k + 8) mod 16), modulo 2^AW.
- R6: Each lane value is {1'b0, byte, 7'b0}; lane k occupies register bytes 2k (upper half) and 2k+1 (lower half), where register byte 0 is `dest_out[127:120]` and byte b is `dest_out[127-8b -: 8]`.
- R7: Register bytes b with start_idx <= b < min(start_idx+8, 16) take the new value; every other byte equals the `dest_in` value sampled at acceptance.
- R8: `done` is high for exactly one cycle, in the cycle after the tenth rising edge following the edge that accepted the request.
- R9: A request raised while a load is in progress causes no reads, no result and no `done`.
- R10: `dest_out` changes only in a cycle where `done` is high and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Load request, accepted when idle |
| base_addr | input | AW | Base byte address |
| offset | input | 7 | Signed offset in 16-byte units |
| start_idx | input | 4 | Start byte index in the destination register |
| dest_in | input | 128 | Previous destination register value |
| mem_rd_en | output | 1 | Byte read strobe |
| mem_addr | output | AW | Byte read address |
| mem_rd_data | input | 8 | Read data, valid the cycle after the strobe |
| done | output | 1 | One-cycle completion pulse |
| dest_out | output | 128 | Merged register value, held until the next completion |

## Verification
On every cycle the assertions watch that done never lasts two cycles, that the output register changes only with done, that a request during a load leaves the captured parameters untouched, that each accepted load issues exactly eight reads, and that successive reads within a half step four bytes apart in the window. The exact addresses, the lane scaling and byte order, the start-dependent merge range and the fixed latency can only be shown by the bench's scenarios. These cover address wrap at the top and bottom of memory, rotation underflow, and starts of 0, 3, 7, 8, 9 and 15.

// File: rtl/strl_pkg.sv
// Shared constants, state type and lane conversion for the strided loader.
// Assumes eight 16-bit lanes in a 128-bit register.
package strl_pkg;
    localparam int LANES      = 8;
    localparam int LANE_W     = 16;
    localparam int REG_W      = LANES * LANE_W;
    localparam int REG_BYTES  = REG_W / 8;
    localparam int IDX_W      = $clog2(REG_BYTES);
    localparam int OFF_W      = 7;
    localparam int ALIGN_BITS = 3;
    localparam int SLOT_W     = $clog2(LANES);
    localparam int SCALE_SH   = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DRAIN = 2'd2,
        ST_MERGE = 2'd3
    } ld_state_e;

    // Zero-extend a byte and scale it by 2^7 into a lane value.
    function automatic logic [LANE_W-1:0] byte_to_lane(input logic [7:0] b);
        logic [LANE_W-1:0] ext;
        ext = LANE_W'(b);
        return ext << SCALE_SH;
    endfunction
endpackage

// File: rtl/strl_addr_gen.sv
// Address generator: captures window base and rotation at acceptance and
// produces the byte address for each lane slot. Assumes AW >= 12.
module strl_addr_gen
    import strl_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              rd_en,
    input  logic [AW-1:0]     base,
    input  logic [OFF_W-1:0]  offset,
    input  logic [IDX_W-1:0]  start,
    input  logic [SLOT_W-1:0] slot_idx,
    output logic [AW-1:0]     rd_addr
);
    localparam int OFF_SH = $clog2(REG_BYTES);

    logic [AW-1:0]    off_ext;
    logic [AW-1:0]    eff_addr;
    logic [AW-1:0]    win_d, win_q;
    logic [IDX_W-1:0] rot_d, rot_q;
    logic [IDX_W-1:0] step;
    logic [IDX_W-1:0] byte_sel;

    // Effective address, window base and rotation from the request fields.
    always_comb begin
        off_ext  = {{(AW-OFF_W){offset[OFF_W-1]}}, offset};
        eff_addr = base + (off_ext << OFF_SH);
        win_d    = {eff_addr[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        rot_d    = IDX_W'(eff_addr[ALIGN_BITS-1:0]) - start;
    end

    // Hold window and rotation for the whole load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
            rot_q <= '0;
        end else if (capture) begin
            win_q <= win_d;
            rot_q <= rot_d;
        end
    end

    // Slot offset: stride four, upper four lanes shifted by eight, mod 16.
    always_comb begin
        step     = {slot_idx[1:0], 2'b00} + (slot_idx[2] ? IDX_W'(8) : IDX_W'(0));
        byte_sel = rot_q + step;
        rd_addr  = win_q + AW'(byte_sel);
    end

    AST_STRIDE_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en) && slot_idx != 3'd0 && slot_idx != 3'd4)
            |-> (4'(rd_addr - $past(rd_addr)) == 4'd4)); // R4
endmodule

// File: rtl/strl_fetch_seq.sv
// Fetch sequencer: accepts a request when idle, issues eight one-byte reads,
// captures returned bytes one cycle later as scaled lanes and signals merge.
// Assumes read data arrives exactly one cycle after each read strobe.
module strl_fetch_seq
    import strl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [7:0]        rd_data,
    output logic              accept,
    output logic              busy,
    output logic              rd_en,
    output logic [SLOT_W-1:0] rd_slot,
    output logic              merge_go,
    output logic [REG_W-1:0]  lanes
);
    ld_state_e         state_q;
    logic [SLOT_W-1:0] cnt_q;
    logic              vld_q;
    logic [SLOT_W-1:0] vidx_q;
    logic [SLOT_W:0]   nreads_q;
    logic [LANE_W-1:0] lane_q [LANES];

    assign accept   = (state_q == ST_IDLE) && req;
    assign busy     = (state_q != ST_IDLE);
    assign rd_en    = (state_q == ST_FETCH);
    assign rd_slot  = cnt_q;
    assign merge_go = (state_q == ST_MERGE);

    // Sequence state and slot counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req) begin
                    state_q <= ST_FETCH;
                    cnt_q   <= '0;
                end
                ST_FETCH: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == SLOT_W'(LANES - 1)) state_q <= ST_DRAIN;
                end
                ST_DRAIN: state_q <= ST_MERGE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Track which slot the returning byte belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            vidx_q <= '0;
        end else begin
            vld_q  <= rd_en;
            vidx_q <= cnt_q;
        end
    end

    // Count reads issued since acceptance, for the read-count check.
    always_ff @(posedge clk) begin
        if (!rst_n)      nreads_q <= '0;
        else if (accept) nreads_q <= '0;
        else if (rd_en)  nreads_q <= nreads_q + 1'b1;
    end

    // One lane register per slot, big-endian packing into the lane vector.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q[k] <= '0;
            else if (vld_q && vidx_q == SLOT_W'(k))
                lane_q[k] <= byte_to_lane(rd_data);
        end
        assign lanes[REG_W-1-k*LANE_W -: LANE_W] = lane_q[k];
    end

    AST_EIGHT_READS: assert property (@(posedge clk) disable iff (!rst_n)
        merge_go |-> (nreads_q == (SLOT_W+1)'(LANES))); // R3
    AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rd_en); // R3
endmodule

// File: rtl/strl_merge.sv
// Byte merge: replaces destination bytes from start up to min(start+8,16)
// with the new lane bytes and keeps the rest. Purely combinational.
module strl_merge
    import strl_pkg::*;
(
    input  logic [REG_W-1:0] new_val,
    input  logic [REG_W-1:0] old_val,
    input  logic [IDX_W-1:0] start,
    output logic [REG_W-1:0] merged
);
    localparam int SPAN = LANES;

    for (genvar b = 0; b < REG_BYTES; b++) begin : g_byte
        logic in_rng;
        // Byte b is in range when start <= b < start + 8 (b < 16 caps the end).
        assign in_rng = ((IDX_W+1)'(b) >= {1'b0, start}) &&
                        ((IDX_W+1)'(b) <  ({1'b0, start} + (IDX_W+1)'(SPAN)));
        assign merged[REG_W-1-8*b -: 8] = in_rng ? new_val[REG_W-1-8*b -: 8]
                                                 : old_val[REG_W-1-8*b -: 8];
    end
endmodule

// File: rtl/strided_lane_loader.sv
// Top: strided byte-to-lane vector loader. Captures request fields when
// idle, runs the fetch sequence and registers the merged result with a
// one-cycle done pulse. Assumes a one-cycle-latency byte memory.
module strided_lane_loader
    import strl_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [AW-1:0]     base_addr,
    input  logic [OFF_W-1:0]  offset,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic [REG_W-1:0]  dest_in,
    output logic              mem_rd_en,
    output logic [AW-1:0]     mem_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              done,
    output logic [REG_W-1:0]  dest_out
);
    logic              accept;
    logic              busy;
    logic              merge_go;
    logic [SLOT_W-1:0] rd_slot;
    logic [REG_W-1:0]  lanes;
    logic [REG_W-1:0]  merged;
    logic [IDX_W-1:0]  start_q;
    logic [REG_W-1:0]  old_q;
    logic [REG_W-1:0]  dest_q;
    logic              done_q;

    strl_fetch_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .rd_data  (mem_rd_data),
        .accept   (accept),
        .busy     (busy),
        .rd_en    (mem_rd_en),
        .rd_slot  (rd_slot),
        .merge_go (merge_go),
        .lanes    (lanes)
    );

    strl_addr_gen #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (accept),
        .rd_en    (mem_rd_en),
        .base     (base_addr),
        .offset   (offset),
        .start    (start_idx),
        .slot_idx (rd_slot),
        .rd_addr  (mem_addr)
    );

    strl_merge u_merge (
        .new_val (lanes),
        .old_val (old_q),
        .start   (start_q),
        .merged  (merged)
    );

    // Capture start index and previous register value at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            old_q   <= '0;
        end else if (accept) begin
            start_q <= start_idx;
            old_q   <= dest_in;
        end
    end

    // Register the merged result and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= merge_go;
            if (merge_go) dest_q <= merged;
        end
    end

    assign done     = done_q;
    assign dest_out = dest_q;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R8
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dest_q) |-> done_q); // R10
    AST_BUSY_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req) |=> ($stable(start_q) && $stable(old_q))); // R9
    AST_NO_READ_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !mem_rd_en); // R3
endmodule

// File: tb/strided_lane_loader_bench.sv
module strided_lane_loader_bench;
    localparam int AW = 12;
    localparam int MEM_N = 1 << AW;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [6:0]   offset = '0;
    logic [3:0]   start_idx = '0;
    logic [127:0] dest_in = '0;
    logic         mem_rd_en;
    logic [AW-1:0] mem_addr;
    logic [7:0]   mem_rd_data = '0;
    logic         done;
    logic [127:0] dest_out;

    logic [7:0]   mem [MEM_N];
    logic [AW-1:0] addr_q [$];
    logic [127:0] res_q [$];
    logic [127:0] last_exp = '0;
    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    strided_lane_loader #(.AW(AW)) u_strided_lane_loader (
        .clk(clk), .rst_n(rst_n), .req(req), .base_addr(base_addr),
        .offset(offset), .start_idx(start_idx), .dest_in(dest_in),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
        .done(done), .dest_out(dest_out)
    );

    initial for (int i = 0; i < MEM_N; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 5));

    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_addr];

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input logic [6:0] o,
                                                input logic [3:0] s, input int k);
        logic [AW-1:0] ea, win;
        logic [3:0] rot, slot;
        ea   = b + ({{(AW-7){o[6]}}, o} << 4);
        win  = {ea[AW-1:3], 3'b000};
        rot  = 4'(ea[2:0]) - s;
        slot = rot + 4'(4 * (k % 4)) + ((k >= 4) ? 4'd8 : 4'd0);
        return win + AW'(slot);
    endfunction

    function automatic logic [127:0] exp_reg(input logic [AW-1:0] b, input logic [6:0] o,
                                             input logic [3:0] s, input logic [127:0] old);
        logic [127:0] nv, r;
        for (int k = 0; k < 8; k++)
            nv[127-16*k -: 16] = {1'b0, mem[exp_addr(b, o, s, k)], 7'b0};
        for (int by = 0; by < 16; by++)
            r[127-8*by -: 8] = (by >= int'(s) && by < int'(s) + 8) ? nv[127-8*by -: 8]
                                                                   : old[127-8*by -: 8];
        return r;
    endfunction

    task automatic check(input bit ok, input string what, input logic [127:0] act,
                         input logic [127:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    // Monitor: compares reads and results against scoreboard queues.
    always @(negedge clk) begin
        if (rst_n && mem_rd_en) begin
            if (addr_q.size() == 0)
                check(0, "R9 unexpected read", 128'(mem_addr), 128'(0));
            else begin
                logic [AW-1:0] ea;
                ea = addr_q.pop_front();
                check(mem_addr == ea, "R2/R3/R4/R5 read address", 128'(mem_addr), 128'(ea));
            end
        end
        if (rst_n && done) begin
            if (res_q.size() == 0)
                check(0, "R9 unexpected done", dest_out, 128'(0));
            else begin
                logic [127:0] er;
                er = res_q.pop_front();
                check(dest_out == er, "R6/R7 merged value", dest_out, er);
            end
        end
    end

    // Driver: pushes expectations, pulses the request, checks latency.
    task automatic run_req(input logic [AW-1:0] b, input logic [6:0] o, input logic [3:0] s,
                           input logic [127:0] old, input bit poke_busy);
        int n;
        for (int k = 0; k < 8; k++) addr_q.push_back(exp_addr(b, o, s, k));
        last_exp = exp_reg(b, o, s, old);
        res_q.push_back(last_exp);
        @(negedge clk);
        base_addr = b; offset = o; start_idx = s; dest_in = old; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        n = 1;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
            if (poke_busy && n == 3) begin
                base_addr = b + 12'h155; start_idx = s + 4'd5; dest_in = ~old; req = 1'b1;
            end else req = 1'b0;
        end
        check(n == 11, "R8 done latency", 128'(n), 128'(11));
        @(negedge clk);
        check(done == 1'b0, "R8 done single cycle", 128'(done), 128'(0));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog act=hung exp=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1 done in reset", 128'(done), 128'(0));
        check(mem_rd_en == 1'b0, "R1 read in reset", 128'(mem_rd_en), 128'(0));
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(done == 1'b0 && mem_rd_en == 1'b0, "R1 idle after reset",
              128'({done, mem_rd_en}), 128'(0));

        run_req(12'h100, 7'd0,   4'd0,  {16{8'hAA}}, 1'b0);
        run_req(12'h123, 7'd5,   4'd3,  {16{8'h5C}}, 1'b0);
        run_req(12'h3F7, 7'h7F,  4'd8,  {8{16'h1234}}, 1'b0);
        run_req(12'hFFA, 7'd63,  4'd9,  {16{8'hE1}}, 1'b0);
        run_req(12'h040, 7'h40,  4'd15, {16{8'h77}}, 1'b0);
        run_req(12'h555, 7'd1,   4'd7,  {4{32'hDEADBEEF}}, 1'b1); // R9 busy poke
        repeat (20) @(negedge clk);
        check(addr_q.size() == 0 && res_q.size() == 0, "R9 no extra activity",
              128'(addr_q.size() + res_q.size()), 128'(0));
        check(dest_out == last_exp, "R10 output held", dest_out, last_exp);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule